// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Unit

This block gives a coarse starting value for 1/sqrt(x) on one IEEE-754 single-precision operand. An iterative refinement stage elsewhere in the datapath would take it from there. For a positive normal operand, the result exponent comes from simple arithmetic on the biased exponent. The result significand is an 8-bit value from a 128-entry table. The table is indexed by the parity of (biased exponent − 1) and the top six fraction bits. All other significand bits of the result are zero.

Special operands are sorted out before the table lookup. The sorting takes them in a fixed priority: NaN first, then zero or denormal, then any other negative value, then positive infinity. The unit also reports an invalid-operation flag. The operand arrives with a valid strobe. The result, its valid strobe and the flag come out of registers one clock later.

Top module: `rsqrt_seed`

## Requirements
- R1: `res_valid` is high in the cycle after each clock edge at which `op_valid` was high, and low after an edge at which `op_valid` was low.
- R2: A synchronous active-high `rst` clears `res_valid`, `res_word` and `res_invalid` to zero.
- R3: For a positive normal operand with biased exponent E (1..254), result bits 30:23 equal 0xBD − floor((E − 1) / 2).
- R4: For a positive normal operand, result bit 31 is 0, bits 14:0 are 0, and bits 22:15 hold the table entry at index {(E − 1) bit 0, operand bits 22:17}. Operand bits 16:0 have no effect.
- R5: The table entries are 253, 252, 245 and 244 at indices 0 to 3. Index 48 holds 131, index 63 holds 108, index 64 holds 103 and index 127 holds 2. Every odd index holds one less than the even index below it.
- R6: Any NaN operand (exponent 0xFF, fraction non-zero), of either sign and either kind, yields 0x7FC00000.
- R7: An operand with exponent field 0 (zero or denormal) yields infinity with the operand's sign: 0x7F800000 or 0xFF800000.
- R8: Any other operand with sign bit 1, including negative infinity, yields 0x7FC00004.
- R9: Positive infinity yields 0x00000000.
- R10: `res_invalid` is 1 exactly when the operand was a signaling NaN (fraction bit 22 clear) or the result is 0x7FC00004. Otherwise it is 0.
- R11: While `op_valid` is low, `res_word` and `res_invalid` keep their previous values, whatever is on `op_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operand strobe |
| op_word | input | 32 | Single-precision operand |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| res_word | output | 32 | Single-precision seed result |
| res_invalid | output | 1 | Invalid-operation flag for the result |

## Verification
The bench aims at the edges of the classification order, where a mistake shows up as a wrong code rather than a slightly wrong number. A negative zero must give negative infinity, not the negative-operand NaN. A negative NaN must give the plain quiet NaN. A signaling NaN must still raise the flag even though its result is the ordinary quiet NaN. It also probes the lowest and highest normal exponents and both exponent parities, where a unit that divided E instead of E − 1 would land one exponent step off, or read the wrong half of the table. The first, last and pair-boundary table entries are checked, and so is the rule that low fraction bits are ignored. Idle cycles with noise on the operand catch a unit that updates its result without a strobe.

// File: rtl/rsqrt_seed.sv
module rsqrt_seed #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [W-1:0] op_word,
  output logic         res_valid,
  output logic [W-1:0] res_word,
  output logic         res_invalid
);
  localparam logic [W-1:0] QNAN_CODE  = 32'h7FC0_0000;
  localparam logic [W-1:0] NEG_CODE   = 32'h7FC0_0004;
  localparam logic [W-1:0] INF_CODE   = 32'h7F80_0000;
  localparam logic [7:0]   EXP_OFFSET = 8'hBD;

  function automatic logic [7:0] pair_val(input logic [5:0] p);
    case (p)
      6'd0:  pair_val = 8'd253;  6'd1:  pair_val = 8'd245;  6'd2:  pair_val = 8'd239;  6'd3:  pair_val = 8'd231;
      6'd4:  pair_val = 8'd225;  6'd5:  pair_val = 8'd217;  6'd6:  pair_val = 8'd211;  6'd7:  pair_val = 8'd205;
      6'd8:  pair_val = 8'd201;  6'd9:  pair_val = 8'd195;  6'd10: pair_val = 8'd189;  6'd11: pair_val = 8'd185;
      6'd12: pair_val = 8'd179;  6'd13: pair_val = 8'd175;  6'd14: pair_val = 8'd169;  6'd15: pair_val = 8'd165;
      6'd16: pair_val = 8'd161;  6'd17: pair_val = 8'd157;  6'd18: pair_val = 8'd153;  6'd19: pair_val = 8'd149;
      6'd20: pair_val = 8'd145;  6'd21: pair_val = 8'd141;  6'd22: pair_val = 8'd137;  6'd23: pair_val = 8'd133;
      6'd24: pair_val = 8'd131;  6'd25: pair_val = 8'd127;  6'd26: pair_val = 8'd123;  6'd27: pair_val = 8'd121;
      6'd28: pair_val = 8'd117;  6'd29: pair_val = 8'd115;  6'd30: pair_val = 8'd111;  6'd31: pair_val = 8'd109;
      6'd32: pair_val = 8'd103;  6'd33: pair_val = 8'd99;   6'd34: pair_val = 8'd93;   6'd35: pair_val = 8'd89;
      6'd36: pair_val = 8'd83;   6'd37: pair_val = 8'd79;   6'd38: pair_val = 8'd75;   6'd39: pair_val = 8'd71;
      6'd40: pair_val = 8'd67;   6'd41: pair_val = 8'd63;   6'd42: pair_val = 8'd59;   6'd43: pair_val = 8'd55;
      6'd44: pair_val = 8'd53;   6'd45: pair_val = 8'd49;   6'd46: pair_val = 8'd45;   6'd47: pair_val = 8'd43;
      6'd48: pair_val = 8'd39;   6'd49: pair_val = 8'd37;   6'd50: pair_val = 8'd33;   6'd51: pair_val = 8'd31;
      6'd52: pair_val = 8'd27;   6'd53: pair_val = 8'd25;   6'd54: pair_val = 8'd23;   6'd55: pair_val = 8'd19;
      6'd56: pair_val = 8'd17;   6'd57: pair_val = 8'd15;   6'd58: pair_val = 8'd13;   6'd59: pair_val = 8'd11;
      6'd60: pair_val = 8'd9;    6'd61: pair_val = 8'd7;    6'd62: pair_val = 8'd5;    default: pair_val = 8'd3;
    endcase
  endfunction

  logic       sgn;
  logic [7:0] ex;
  logic [22:0] fr;
  logic [7:0] ex_m1;
  logic [6:0] idx;
  logic [7:0] seed_m;
  logic [7:0] seed_e;
  logic       is_nan, is_snan, is_zd, is_inf;
  logic [W-1:0] nxt_word;
  logic       nxt_inv;

  assign sgn     = op_word[31];
  assign ex      = op_word[30:23];
  assign fr      = op_word[22:0];
  assign ex_m1   = ex - 8'd1;
  assign idx     = {ex_m1[0], fr[22:17]};
  assign seed_m  = pair_val(idx[6:1]) - {7'd0, idx[0]};
  assign seed_e  = EXP_OFFSET - {1'b0, ex_m1[7:1]};
  assign is_nan  = (&ex) && (|fr);
  assign is_snan = is_nan && !fr[22];
  assign is_zd   = (ex == 8'd0);
  assign is_inf  = (&ex) && (fr == 23'd0);

  always_comb begin
    if (is_nan)       nxt_word = QNAN_CODE;
    else if (is_zd)   nxt_word = INF_CODE | {sgn, 31'd0};
    else if (sgn)     nxt_word = NEG_CODE;
    else if (is_inf)  nxt_word = '0;
    else              nxt_word = {1'b0, seed_e, seed_m, 15'd0};
  end

  assign nxt_inv = is_snan || (!is_nan && !is_zd && sgn);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_word    <= '0;
      res_invalid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_word    <= nxt_word;
        res_invalid <= nxt_inv;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) op_valid |=> res_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !op_valid |=> !res_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !op_valid |=> ($stable(res_word) && $stable(res_invalid))); // R11
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst) (res_valid && res_word != NEG_CODE) |-> res_word[14:0] == 15'd0); // R4
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst) (res_valid && res_word == NEG_CODE) |-> res_invalid); // R10
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst) (op_valid && (&op_word[30:23]) && (|op_word[21:0]) && !op_word[22]) |=> (res_invalid && res_word == QNAN_CODE)); // R10
  AST_POS_SIGN: assert property (@(posedge clk) disable iff (rst) (op_valid && !op_word[31] && op_word[30:23] != 8'd0 && op_word[30:23] != 8'hFF) |=> !res_word[31]); // R4
endmodule

// File: tb/rsqrt_seed_tb.sv
module rsqrt_seed_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] op_word = '0;
  logic        res_valid;
  logic [31:0] res_word;
  logic        res_invalid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  logic [31:0] q_word[$];
  logic        q_inv[$];
  string       q_tag[$];
  logic [31:0] last_word = '0;
  logic        last_inv  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsqrt_seed dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .res_valid(res_valid), .res_word(res_word), .res_invalid(res_invalid)
  );

  function automatic logic [31:0] norm_exp(input logic [7:0] e, input logic [7:0] m);
    logic [7:0] ne;
    ne = 8'd189 - 8'((int'(e) - 1) / 2);
    return {1'b0, ne, m, 15'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp_v);
    end
  endtask

  task automatic send(input logic [31:0] op, input logic [31:0] ew, input logic ei, input string tag);
    @(negedge clk);
    op_valid = 1'b1;
    op_word  = op;
    q_word.push_back(ew);
    q_inv.push_back(ei);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input logic [31:0] noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      op_word  = noise ^ 32'(i * 32'h0101_3579);
    end
  endtask

  initial begin : monitor
    @(negedge clk);
    check("R2 reset valid", {31'd0, res_valid}, 32'd0);
    check("R2 reset word", res_word, 32'd0);
    check("R2 reset invalid", {31'd0, res_invalid}, 32'd0);
    wait (!rst);
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (q_word.size() == 0) begin
          check("R1 unexpected res_valid", 32'd1, 32'd0);
        end else begin
          logic [31:0] ew;
          logic ei;
          string tg;
          ew = q_word.pop_front();
          ei = q_inv.pop_front();
          tg = q_tag.pop_front();
          check(tg, res_word, ew);
          check({tg, " R10 flag"}, {31'd0, res_invalid}, {31'd0, ei});
          last_word = ew;
          last_inv  = ei;
        end
      end else if (q_word.size() != 0 && !op_valid) begin
        check("R1 result missing", 32'd0, 32'd1);
        void'(q_word.pop_front()); void'(q_inv.pop_front()); void'(q_tag.pop_front());
      end else begin
        check("R11 hold word", res_word, last_word);
        check("R11 hold invalid", {31'd0, res_invalid}, {31'd0, last_inv});
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 R4 R5 table and exponent
    send(32'h3F80_0000, norm_exp(8'd127, 8'd253), 1'b0, "R5 idx0 one");
    send(32'h3F82_0000, norm_exp(8'd127, 8'd252), 1'b0, "R5 idx1");
    send(32'h3F84_0000, norm_exp(8'd127, 8'd245), 1'b0, "R5 idx2");
    send(32'h3F86_0000, norm_exp(8'd127, 8'd244), 1'b0, "R5 idx3");
    send(32'h3FE0_0000, norm_exp(8'd127, 8'd131), 1'b0, "R5 idx48");
    send(32'h3FFF_FFFF, norm_exp(8'd127, 8'd108), 1'b0, "R5 idx63");
    send(32'h4000_0000, norm_exp(8'd128, 8'd103), 1'b0, "R3 odd parity idx64");
    send(32'h407E_0000, norm_exp(8'd128, 8'd2),   1'b0, "R5 idx127");
    send(32'h4080_0000, norm_exp(8'd129, 8'd253), 1'b0, "R3 four");
    send(32'h3F80_FFFF, norm_exp(8'd127, 8'd253), 1'b0, "R4 low bits ignored");
    send(32'h0080_0000, 32'h5EFE_8000, 1'b0, "R3 min normal");
    send(32'h7F7F_FFFF, 32'h1F81_0000, 1'b0, "R3 max normal");
    idle(3, 32'hDEAD_BEEF);
    // R6 NaNs
    send(32'h7FC0_0000, 32'h7FC0_0000, 1'b0, "R6 qnan");
    send(32'hFFC1_2345, 32'h7FC0_0000, 1'b0, "R6 neg qnan");
    send(32'h7FC0_0004, 32'h7FC0_0000, 1'b0, "R6 qnan payload");
    send(32'h7F80_0001, 32'h7FC0_0000, 1'b1, "R6 snan");
    send(32'hFFA0_0000, 32'h7FC0_0000, 1'b1, "R6 neg snan");
    idle(2, 32'hBF80_0000);
    // R7 zero and denormal
    send(32'h0000_0000, 32'h7F80_0000, 1'b0, "R7 pos zero");
    send(32'h8000_0000, 32'hFF80_0000, 1'b0, "R7 neg zero");
    send(32'h0000_0001, 32'h7F80_0000, 1'b0, "R7 pos denorm");
    send(32'h807F_FFFF, 32'hFF80_0000, 1'b0, "R7 neg denorm");
    // R8 R9
    send(32'hBF80_0000, 32'h7FC0_0004, 1'b1, "R8 neg one");
    send(32'hFF80_0000, 32'h7FC0_0004, 1'b1, "R8 neg inf");
    send(32'h7F80_0000, 32'h0000_0000, 1'b0, "R9 pos inf");
    idle(4, 32'h7F80_0001);
    send(32'h4000_0000, norm_exp(8'd128, 8'd103), 1'b0, "R1 after gap");
    idle(3, 32'h8000_0000);
    wait (q_word.size() == 0);
    idle(2, 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule